// File: doc/BRIEF.md
# Multi-Channel Round-Robin DMA Engine

This block moves blocks of words across one shared memory bus for several requesting clients. Each client offers a descriptor with a strobe: a source word address, a destination word address and a word count. The engine holds a small pool of channel slots, and a client is not tied to any one slot. An intake picker copies one pending descriptor into a free slot per cycle and answers with an acknowledge. A second picker starts one loaded slot at a time on the bus.

Each word takes two bus phases: a read at the source address, then a write of the captured word to the destination address. Both addresses then step up by one and the count steps down by one. The running slot keeps the bus until its block ends. When it ends, a one-cycle done pulse goes out on the bit of the client that posted the descriptor, and the slot becomes free again.

Top module: `mcdma_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all slots become free, both pickers point at index 0, and `req_ack`, `req_done`, `bus_req`, `bus_rd` and `bus_wr` are low in the next cycle.
- R2: In any cycle with at least one free slot, `req_ack` is the combinational one-hot of the first client with `req_valid` high, searching cyclically from the intake pointer. That client's descriptor is stored at the next edge in the lowest-numbered free slot.
- R3: In a cycle with no free slot, `req_ack` is all zero. A client whose strobe is high stays pending, and it is accepted in a later cycle once a slot frees.
- R4: After an acknowledge to client k, the intake pointer becomes k+1 modulo the client count. After a slot s is started, the execution pointer becomes s+1 modulo the slot count.
- R5: When no slot is running, the engine starts the first loaded slot, searching cyclically from the execution pointer. A slot loaded at an edge can be started at the following edge at the earliest.
- R6: A started slot with a nonzero count performs, for each word, a read phase (`bus_rd` high, `bus_addr` = current source) followed by a write phase (`bus_wr` high, `bus_addr` = current destination, `bus_wdata` = the word read). A phase completes at an edge where `bus_grant` and `bus_ready` are both high, and `bus_rd` and `bus_wr` are high only while `bus_grant` is high.
- R7: After each completed write phase, the source and destination step up by one and the remaining count steps down by one. `bus_req` stays high from the start of a slot until its last write completes. A low `bus_grant` or `bus_ready` holds the phase and the address unchanged.
- R8: The cycle after the last write phase completes, `req_done` has exactly one bit high, at the index of the posting client, for exactly one cycle. The slot is free again from that same edge.
- R9: A descriptor with a count of zero, once started, frees its slot and pulses the owner's `req_done` bit in the next cycle, with no read or write phase.
- R10: `bus_rd` and `bus_wr` are never high together, and neither `req_ack` nor `req_done` ever has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_REQ | Per-client descriptor strobe |
| req_src | input | NUM_REQ*ADDR_W | Packed source addresses, client k at bits k*ADDR_W upward |
| req_dst | input | NUM_REQ*ADDR_W | Packed destination addresses |
| req_len | input | NUM_REQ*LEN_W | Packed word counts |
| req_ack | output | NUM_REQ | One-hot acceptance, same cycle as capture |
| req_done | output | NUM_REQ | One-cycle completion pulse on the owner's bit |
| bus_req | output | 1 | A slot is running and wants the bus |
| bus_grant | input | 1 | Bus ownership granted to the engine |
| bus_rd | output | 1 | Read phase strobe |
| bus_wr | output | 1 | Write phase strobe |
| bus_addr | output | ADDR_W | Word address of the current phase |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled when a read phase completes |
| bus_ready | input | 1 | Memory accepts or returns the current phase |

## Verification
A single descriptor on an always-granted bus pins the exact phase count and cycle placement of each read and write. Four clients posting at once against two slots show that surplus requests wait and are not dropped, and the resulting acknowledge order shows how the intake pointer rotates. A zero-count descriptor separates "finish without bus activity" from "one spurious word". A final run with randomly withheld grant and ready, and one client flooding four descriptors, shows that pauses keep address and data intact and that the flooding client cannot push the others back.

// File: rtl/mcdma_pkg.sv
// Shared types for the multi-channel DMA engine.
package mcdma_pkg;

    // Life cycle of one channel slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_QUEUED  = 2'd1,
        SLOT_RUNNING = 2'd2
    } slot_state_t;

    // Bus phase of the word mover.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } move_phase_t;

endpackage

// File: rtl/mcdma_rr_pick.sv
// Round-robin picker.
// Grants the first asserted request found by searching cyclically upward
// from index ptr. Purely combinational; the caller owns the pointer register.
// Assumes ptr < N.
module mcdma_rr_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Cyclic first-one search starting at ptr.
    always_comb begin
        int pos;
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            pos = (int'(ptr) + i) % N;
            if (!any && req[pos]) begin
                any      = 1'b1;
                gnt[pos] = 1'b1;
                idx      = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/mcdma_mover.sv
// Word mover for the running channel.
// On load it copies source, destination and count into working registers.
// For each word it does a read phase and then a write phase. A phase
// completes at an edge with bus_grant and bus_ready both high. fin is high
// in the cycle whose edge completes the last write.
// Assumes load is raised only while busy is low and only with ld_len != 0.
module mcdma_mover
    import mcdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [LEN_W-1:0]  ld_len,
    output logic              busy,
    output logic              fin,
    input  logic              bus_grant,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    move_phase_t       phase;
    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [LEN_W-1:0]  left;
    logic [DATA_W-1:0] hold;
    logic              step;

    // A phase advances only on a granted and ready edge.
    assign step      = bus_grant && bus_ready;
    assign busy      = (phase != PH_IDLE);
    assign bus_req   = busy;
    assign bus_rd    = (phase == PH_READ)  && bus_grant;
    assign bus_wr    = (phase == PH_WRITE) && bus_grant;
    assign bus_addr  = (phase == PH_WRITE) ? cur_dst : cur_src;
    assign bus_wdata = hold;
    assign fin       = (phase == PH_WRITE) && step && (left == LEN_W'(1));

    // Phase sequencing plus the address and count datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cur_src <= '0;
            cur_dst <= '0;
            left    <= '0;
            hold    <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (load) begin
                    cur_src <= ld_src;
                    cur_dst <= ld_dst;
                    left    <= ld_len;
                    phase   <= PH_READ;
                end
                PH_READ: if (step) begin
                    hold  <= bus_rdata;
                    phase <= PH_WRITE;
                end
                PH_WRITE: if (step) begin
                    cur_src <= cur_src + ADDR_W'(1);
                    cur_dst <= cur_dst + ADDR_W'(1);
                    left    <= left - LEN_W'(1);
                    phase   <= (left == LEN_W'(1)) ? PH_IDLE : PH_READ;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mcdma_top.sv
// Multi-channel round-robin DMA engine.
// Clients post descriptors into a pool of slots through a round-robin intake
// picker. A second round-robin picker starts one queued slot at a time on
// the word mover. Completion pulses the owning client's done bit.
// Assumes each client holds its strobe and descriptor until it sees its ack.
module mcdma_top
    import mcdma_pkg::*;
#(
    parameter int NUM_REQ  = 4,
    parameter int NUM_SLOT = 2,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int LEN_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*ADDR_W-1:0] req_src,
    input  logic [NUM_REQ*ADDR_W-1:0] req_dst,
    input  logic [NUM_REQ*LEN_W-1:0]  req_len,
    output logic [NUM_REQ-1:0]        req_ack,
    output logic [NUM_REQ-1:0]        req_done,
    output logic                      bus_req,
    input  logic                      bus_grant,
    output logic                      bus_rd,
    output logic                      bus_wr,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_wdata,
    input  logic [DATA_W-1:0]         bus_rdata,
    input  logic                      bus_ready
);

    localparam int RIW = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1;
    localparam int SIW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

    // Unpacked views of the client descriptors.
    logic [ADDR_W-1:0] cl_src [NUM_REQ];
    logic [ADDR_W-1:0] cl_dst [NUM_REQ];
    logic [LEN_W-1:0]  cl_len [NUM_REQ];

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_unpack
        assign cl_src[r] = req_src[r*ADDR_W +: ADDR_W];
        assign cl_dst[r] = req_dst[r*ADDR_W +: ADDR_W];
        assign cl_len[r] = req_len[r*LEN_W  +: LEN_W];
    end

    // Slot storage.
    slot_state_t       slot_st  [NUM_SLOT];
    logic [ADDR_W-1:0] slot_src [NUM_SLOT];
    logic [ADDR_W-1:0] slot_dst [NUM_SLOT];
    logic [LEN_W-1:0]  slot_len [NUM_SLOT];
    logic [RIW-1:0]    slot_own [NUM_SLOT];
    logic [NUM_SLOT-1:0] empty_v;
    logic [NUM_SLOT-1:0] queued_v;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_flags
        assign empty_v[s]  = (slot_st[s] == SLOT_EMPTY);
        assign queued_v[s] = (slot_st[s] == SLOT_QUEUED);
    end

    // Lowest-numbered free slot receives the next descriptor.
    logic [SIW-1:0] free_idx;
    logic           have_free;
    assign have_free = |empty_v;
    always_comb begin
        free_idx = '0;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (empty_v[s]) free_idx = SIW'(s);
        end
    end

    // Intake arbitration among clients.
    logic [RIW-1:0]     in_ptr;
    logic [NUM_REQ-1:0] in_gnt;
    logic [RIW-1:0]     in_idx;
    logic               in_any;

    mcdma_rr_pick #(.N(NUM_REQ)) u_intake (
        .req (req_valid & {NUM_REQ{have_free}}),
        .ptr (in_ptr),
        .gnt (in_gnt),
        .idx (in_idx),
        .any (in_any)
    );
    assign req_ack = in_gnt;

    // Execution arbitration among queued slots.
    logic [SIW-1:0]      ex_ptr;
    logic [NUM_SLOT-1:0] ex_gnt;
    logic [SIW-1:0]      ex_idx;
    logic                ex_any;
    logic                mv_busy;
    logic                mv_fin;
    logic                mv_load;
    logic                sel_zero;
    logic [SIW-1:0]      act_slot;

    mcdma_rr_pick #(.N(NUM_SLOT)) u_exec (
        .req (queued_v & {NUM_SLOT{~mv_busy}}),
        .ptr (ex_ptr),
        .gnt (ex_gnt),
        .idx (ex_idx),
        .any (ex_any)
    );
    assign sel_zero = (slot_len[ex_idx] == '0);
    assign mv_load  = ex_any && !sel_zero;

    mcdma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mv_load),
        .ld_src    (slot_src[ex_idx]),
        .ld_dst    (slot_dst[ex_idx]),
        .ld_len    (slot_len[ex_idx]),
        .busy      (mv_busy),
        .fin       (mv_fin),
        .bus_grant (bus_grant),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Both round-robin pointers move to just past their last grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ptr <= '0;
            ex_ptr <= '0;
        end else begin
            if (in_any) in_ptr <= (int'(in_idx) == NUM_REQ - 1)  ? '0 : in_idx + RIW'(1);
            if (ex_any) ex_ptr <= (int'(ex_idx) == NUM_SLOT - 1) ? '0 : ex_idx + SIW'(1);
        end
    end

    // Remember which slot the mover is serving.
    always_ff @(posedge clk) begin
        if (!rst_n)       act_slot <= '0;
        else if (mv_load) act_slot <= ex_idx;
    end

    // Slot fill, start and release; the three touch slots of different states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                slot_st[s]  <= SLOT_EMPTY;
                slot_src[s] <= '0;
                slot_dst[s] <= '0;
                slot_len[s] <= '0;
                slot_own[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (in_any && free_idx == SIW'(s)) begin
                    slot_st[s]  <= SLOT_QUEUED;
                    slot_src[s] <= cl_src[in_idx];
                    slot_dst[s] <= cl_dst[in_idx];
                    slot_len[s] <= cl_len[in_idx];
                    slot_own[s] <= in_idx;
                end
                if (ex_any && ex_idx == SIW'(s))
                    slot_st[s] <= sel_zero ? SLOT_EMPTY : SLOT_RUNNING;
                if (mv_fin && act_slot == SIW'(s))
                    slot_st[s] <= SLOT_EMPTY;
            end
        end
    end

    // Registered one-cycle done pulse routed by the owner tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_done <= '0;
        end else begin
            req_done <= '0;
            if (ex_any && sel_zero) req_done[slot_own[ex_idx]]   <= 1'b1;
            else if (mv_fin)        req_done[slot_own[act_slot]] <= 1'b1;
        end
    end

endmodule

// File: rtl/mcdma_sva.sv
// Port-level protocol checks for mcdma_top, attached with bind below.
module mcdma_sva #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_ack,
    input logic [NUM_REQ-1:0] req_done,
    input logic               bus_req,
    input logic               bus_grant,
    input logic               bus_ready,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr
);

    // R2: a single acknowledge, only to a strobing client.
    p_one_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack));
    p_ack_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack & ~req_valid) == '0);

    // R8: at most one completion per cycle.
    p_one_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_done));

    // R10: read and write never overlap.
    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R6: strobes only under grant; a finished read is followed by a write.
    p_phase_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_grant);
    p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> (bus_req && !bus_rd));

    // R7: a stalled phase keeps the bus request and the address.
    p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_grant && bus_ready)) |=> (bus_req && $stable(bus_addr)));

endmodule

bind mcdma_top mcdma_sva #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_done  (req_done),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .bus_ready (bus_ready),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr)
);

// File: tb/mcdma_top_test.sv
`timescale 1ns/1ps
// Bench for mcdma_top: a behavioural cycle model is compared on every
// falling edge. A word memory answers the bus, and queues play the clients.
module mcdma_top_test;

    localparam int NR = 4;
    localparam int NS = 2;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int LW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     req_valid;
    logic [NR*AW-1:0]  req_src;
    logic [NR*AW-1:0]  req_dst;
    logic [NR*LW-1:0]  req_len;
    logic [NR-1:0]     req_ack;
    logic [NR-1:0]     req_done;
    logic              bus_req;
    logic              bus_grant;
    logic              bus_rd;
    logic              bus_wr;
    logic [AW-1:0]     bus_addr;
    logic [DW-1:0]     bus_wdata;
    logic [DW-1:0]     bus_rdata;
    logic              bus_ready;

    mcdma_top #(.NUM_REQ(NR), .NUM_SLOT(NS), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_dst(req_dst), .req_len(req_len), .req_ack(req_ack), .req_done(req_done),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    always #2.5 clk = ~clk;

    // Environment: memory, golden image, client queues.
    logic [DW-1:0] mem  [256];
    logic [DW-1:0] gold [256];
    assign bus_rdata = mem[bus_addr[7:0]];

    int q_src [NR][$];
    int q_dst [NR][$];
    int q_len [NR][$];
    int posted   [NR];
    int done_obs [NR];
    int ack_log  [$];
    int n_phase;
    int n_chk;
    int n_err;
    bit g_rand;
    bit r_rand;
    bit finished;
    logic [15:0] lfsr = 16'hACE1;

    // Behavioural reference state: 0 free, 1 queued, 2 running.
    int m_st [NS];
    int m_own [NS];
    int m_src [NS];
    int m_dst [NS];
    int m_len [NS];
    int m_pin, m_pex, m_ph, m_slot, w_src, w_dst, w_left, m_done;
    logic [DW-1:0] w_hold;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic post(input int r, input int s, input int d, input int l);
        q_src[r].push_back(s);
        q_dst[r].push_back(d);
        q_len[r].push_back(l);
        posted[r]++;
        for (int i = 0; i < l; i++) gold[d+i] = gold[s+i];
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_st[s] = 0; m_own[s] = 0; m_src[s] = 0; m_dst[s] = 0; m_len[s] = 0;
        end
        m_pin = 0; m_pex = 0; m_ph = 0; m_slot = 0; m_done = -1;
        w_src = 0; w_dst = 0; w_left = 0; w_hold = '0;
    endtask

    // Compare this cycle's outputs, then advance the model by one edge.
    task automatic model_step();
        int free, e_ack, e_sel, nd, r, s;
        logic [NR-1:0] x_ack;
        logic [NR-1:0] x_done;
        free = -1;
        for (int k = NS - 1; k >= 0; k--) if (m_st[k] == 0) free = k;
        e_ack = -1;
        if (free >= 0)
            for (int i = 0; i < NR; i++) begin
                r = (m_pin + i) % NR;
                if (e_ack < 0 && req_valid[r]) e_ack = r;
            end
        x_ack = '0;
        if (e_ack >= 0) x_ack[e_ack] = 1'b1;
        // R2 R3 R4: who is acknowledged this cycle
        chk(req_ack == x_ack, (free < 0) ? "R3" : "R2 R4", "ack", req_ack, x_ack);
        x_done = '0;
        if (m_done >= 0) x_done[m_done] = 1'b1;
        chk(req_done == x_done, "R8 R9", "done", req_done, x_done);
        chk(bus_req == (m_ph != 0), "R7", "bus_req", bus_req, m_ph != 0);
        chk(bus_rd == (m_ph == 1 && bus_grant), "R6", "bus_rd", bus_rd, m_ph == 1 && bus_grant);
        chk(bus_wr == (m_ph == 2 && bus_grant), "R6", "bus_wr", bus_wr, m_ph == 2 && bus_grant);
        if (m_ph == 1 && bus_grant)
            chk(bus_addr == AW'(w_src), "R7", "read addr", bus_addr, w_src);
        if (m_ph == 2 && bus_grant) begin
            chk(bus_addr == AW'(w_dst), "R7", "write addr", bus_addr, w_dst);
            chk(bus_wdata == w_hold, "R6", "write data", bus_wdata, w_hold);
        end
        // R5: execution pick from the snapshot
        e_sel = -1;
        if (m_ph == 0)
            for (int i = 0; i < NS; i++) begin
                s = (m_pex + i) % NS;
                if (e_sel < 0 && m_st[s] == 1) e_sel = s;
            end
        nd = -1;
        if (bus_grant && bus_ready) begin
            if (m_ph == 1) begin
                w_hold = mem[w_src % 256];
                m_ph = 2;
            end else if (m_ph == 2) begin
                w_src++; w_dst++; w_left--;
                if (w_left == 0) begin
                    m_st[m_slot] = 0;
                    nd = m_own[m_slot];
                    m_ph = 0;
                end else begin
                    m_ph = 1;
                end
            end
        end
        if (e_sel >= 0) begin
            m_pex = (e_sel + 1) % NS;
            if (m_len[e_sel] == 0) begin
                m_st[e_sel] = 0;
                nd = m_own[e_sel];
            end else begin
                m_st[e_sel] = 2;
                m_slot = e_sel;
                w_src = m_src[e_sel]; w_dst = m_dst[e_sel]; w_left = m_len[e_sel];
                m_ph = 1;
            end
        end
        if (e_ack >= 0) begin
            m_st[free]  = 1;
            m_own[free] = e_ack;
            m_src[free] = int'(req_src[e_ack*AW +: AW]);
            m_dst[free] = int'(req_dst[e_ack*AW +: AW]);
            m_len[free] = int'(req_len[e_ack*LW +: LW]);
            m_pin = (e_ack + 1) % NR;
        end
        m_done = nd;
    endtask

    // Client side and memory side reactions to the design's outputs.
    task automatic observe();
        for (int r = 0; r < NR; r++) begin
            if (req_ack[r] && q_src[r].size() > 0) begin
                void'(q_src[r].pop_front());
                void'(q_dst[r].pop_front());
                void'(q_len[r].pop_front());
                ack_log.push_back(r);
            end
            if (req_done[r]) done_obs[r]++;
        end
        if (bus_rd || bus_wr) n_phase++;
        if (bus_wr && bus_ready) mem[bus_addr[7:0]] = bus_wdata;
    endtask

    // Falling-edge compare and step.
    initial begin
        model_reset();
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                model_reset();
                chk(req_ack == '0 && req_done == '0 && !bus_req && !bus_rd && !bus_wr,
                    "R1", "outputs under reset", {req_ack, req_done, bus_req, bus_rd, bus_wr}, 0);
            end else begin
                model_step();
                observe();
            end
        end
    end

    // Input driver, just after each rising edge.
    initial begin
        req_valid = '0; req_src = '0; req_dst = '0; req_len = '0;
        bus_grant = 1'b0; bus_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_grant = rst_n && (g_rand ? (lfsr[0] | lfsr[4]) : 1'b1);
            bus_ready = r_rand ? (lfsr[2] | lfsr[7]) : 1'b1;
            for (int r = 0; r < NR; r++) begin
                if (rst_n && q_src[r].size() > 0) begin
                    req_valid[r] = 1'b1;
                    req_src[r*AW +: AW] = AW'(q_src[r][0]);
                    req_dst[r*AW +: AW] = AW'(q_dst[r][0]);
                    req_len[r*LW +: LW] = LW'(q_len[r][0]);
                end else begin
                    req_valid[r] = 1'b0;
                end
            end
        end
    end

    function automatic bit all_idle();
        int p, d;
        p = 0; d = 0;
        for (int r = 0; r < NR; r++) begin
            if (q_src[r].size() > 0) return 1'b0;
            p += posted[r];
            d += done_obs[r];
        end
        return (p == d) && !bus_req;
    endfunction

    task automatic wait_idle(input string tag);
        bit ok;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            if (all_idle()) begin ok = 1'b1; break; end
        end
        chk(ok, tag, "descriptors drained", ok, 1);
        repeat (3) @(posedge clk);
    endtask

    task automatic check_order(input string tag, input int exp_q[$]);
        chk(ack_log.size() == exp_q.size(), tag, "ack count", ack_log.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < ack_log.size(); i++)
            chk(ack_log[i] == exp_q[i], tag, "ack order", ack_log[i], exp_q[i]);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        summary();
    end

    // Scenarios.
    initial begin
        int ph0, mism;
        int o3[$];
        int o4[$];
        n_chk = 0; n_err = 0; n_phase = 0; finished = 1'b0;
        g_rand = 1'b0; r_rand = 1'b0;
        for (int r = 0; r < NR; r++) begin posted[r] = 0; done_obs[r] = 0; end
        for (int i = 0; i < 256; i++) begin
            mem[i]  = DW'(i * 37 + 5);
            gold[i] = mem[i];
        end
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs right after reset release
        chk(req_done == '0 && !bus_req, "R1", "idle after reset", {req_done, bus_req}, 0);

        // R6 R7: single three-word block on a free bus, six phases exactly
        post(0, 'h10, 'h80, 3);
        wait_idle("R5");
        chk(n_phase == 6, "R6", "phase count for 3 words", n_phase, 6);
        chk(done_obs[0] == 1, "R8", "done count client 0", done_obs[0], 1);

        // R9: zero-count descriptor, no bus phases
        ph0 = n_phase;
        post(1, 'h00, 'h88, 0);
        wait_idle("R9");
        chk(n_phase == ph0, "R9", "bus phases for zero count", n_phase, ph0);
        chk(done_obs[1] == 1, "R9", "done for zero count", done_obs[1], 1);

        // R3 R4: four clients against two slots
        ack_log.delete();
        post(0, 'h20, 'h90, 2);
        post(1, 'h24, 'h98, 4);
        post(2, 'h28, 'hA0, 1);
        post(3, 'h2C, 'hA8, 3);
        wait_idle("R3");
        o3 = '{2, 3, 0, 1};
        check_order("R4", o3);

        // R7 R4: random grant and ready, client 0 floods
        g_rand = 1'b1; r_rand = 1'b1;
        ack_log.delete();
        post(0, 'h30, 'hB0, 2);
        post(0, 'h34, 'hB4, 3);
        post(0, 'h38, 'hB8, 0);
        post(0, 'h3C, 'hBC, 2);
        post(1, 'h40, 'hC0, 5);
        post(2, 'h48, 'hC8, 1);
        post(3, 'h50, 'hD0, 4);
        wait_idle("R7");
        o4 = '{2, 3, 0, 1, 0, 0, 0};
        check_order("R4", o4);

        // R6 R7: memory image after every copy
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== gold[i]) mism++;
        chk(mism == 0, "R7", "memory words wrong", mism, 0);
        for (int r = 0; r < NR; r++)
            chk(done_obs[r] == posted[r], "R8", "done pulses per client", done_obs[r], posted[r]);
        summary();
    end

endmodule